// File: doc/BRIEF.md
# ROM Fetch and Branch Coverage Counter

This block sits beside a small processor core and watches its bus. Every time the core fetches an instruction from the top 512 bytes of its address space (the ROM window 16'hFE00 to 16'hFFFF), the counter kept for that address goes up by one. When the fetched opcode is a conditional branch, the block also waits for the core to report the branch outcome on the next bus cycle it accepts, and counts that outcome in one of two bins kept per ROM address: one for taken and one for fall-through.

Fetches that land outside the ROM window are not counted per address, but a single wider counter records how many there were. All counters saturate instead of wrapping, and one clear input zeroes every counter at once. A combinational readback port returns the fetch count and one branch bin for any address, so firmware tests can see which instructions ran and which branch directions were exercised.

Top module: `rom_fetch_cov`

## Requirements
- R1: Bus activity is only sampled on rising clock edges where `stb` and `ack` are both 1 and `rst_n` is 1; any other cycle changes no counter and no branch tracking state.
- R2: A sampled fetch (`fetch`=1) at an address in 16'hFE00..16'hFFFF adds one to that address's fetch counter, which `rd_fetch_cnt` shows when `rd_addr` equals that address.
- R3: Per-address fetch counters and branch bins are 8 bits wide and stay at 255 once they reach it.
- R4: A fetched opcode whose bits [4:0] equal 5'h10 is a conditional branch; on the next sampled cycle after that fetch, the bin selected by {fetch address, `taken`} gains one, and `rd_branch_cnt` shows the bin chosen by {`rd_addr`, `rd_taken`} (`rd_taken`=1 is the taken bin, 0 the fall-through bin).
- R5: Sampled fetches whose opcode bits [4:0] differ from 5'h10 leave every branch bin unchanged.
- R6: A sampled fetch outside the window changes no per-address counter and adds one to `outside_cnt`, a 16-bit counter that stays at 65535 once it gets there.
- R7: `clr`=1 on a clock edge with `rst_n`=1 zeroes all counters, winning over any count event in that same cycle.
- R8: With `rst_n`=0 on a clock edge all counters and the branch tracking state go to zero.
- R9: With `rd_addr` outside the window, `rd_fetch_cnt` and `rd_branch_cnt` read 0.
- R10: The branch outcome is taken from the next sampled cycle, however many unsampled cycles lie between, and a branch fetched outside the window fills no bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Zero all counters |
| stb | input | 1 | Core bus strobe |
| ack | input | 1 | Core bus acknowledge |
| fetch | input | 1 | Current bus cycle is an instruction fetch |
| addr | input | 16 | Bus address |
| rdata | input | 8 | Read data (opcode on a fetch) |
| taken | input | 1 | Branch outcome from the core |
| rd_addr | input | 16 | Readback address |
| rd_taken | input | 1 | Readback branch bin select |
| rd_fetch_cnt | output | 8 | Fetch count at `rd_addr` |
| rd_branch_cnt | output | 8 | Branch bin count at {`rd_addr`, `rd_taken`} |
| outside_cnt | output | 16 | Count of fetches outside the window |

## Verification
The bench aims at the outcome timing: a branch followed by idle or unacknowledged cycles, or straight by another fetch, where a design resolving the outcome on the next clock rather than the next accepted cycle would fill the wrong bin or none. It drives counters past 255 and the outside counter past 65535, where a missing saturation shows as a wrap to a small count. It asserts clear together with a fetch, where wrong priority leaves a count of 1, and probes addresses just outside both window edges, where an off-by-one decode counts a stray fetch or aliases a readback.

// File: rtl/cov_pkg.sv
// Shared constants and helpers for the ROM coverage counter.
// Assumes an 8-bit opcode whose low five bits identify a conditional branch.
package cov_pkg;
    localparam int OPC_W         = 8;
    localparam int BR_FIELD_W    = 5;
    localparam logic [BR_FIELD_W-1:0] BR_FIELD_CODE = 5'h10;

    // True when the opcode is a conditional branch.
    function automatic logic is_cond_branch(input logic [OPC_W-1:0] opc);
        return opc[BR_FIELD_W-1:0] == BR_FIELD_CODE;
    endfunction
endpackage

// File: rtl/cov_fetch_capture.sv
// Turns raw bus cycles into count events: window hit with index, window miss,
// and a resolved branch bin. Assumes the branch outcome is valid on the first
// accepted bus cycle after the fetch of the branch opcode.
module cov_fetch_capture #(
    parameter int ADDR_W   = 16,
    parameter int WIN_LOG2 = 9,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFE00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic                ack,
    input  logic                fetch,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          rdata,
    input  logic                taken,
    output logic                hit_vld,
    output logic [WIN_LOG2-1:0] hit_idx,
    output logic                miss_vld,
    output logic                br_vld,
    output logic [WIN_LOG2:0]   br_bin
);
    import cov_pkg::*;

    localparam int TAG_W = ADDR_W - WIN_LOG2;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

    logic              sampled;
    logic              in_win;
    logic [ADDR_W-1:0] lat_addr;
    logic [7:0]        lat_opc;
    logic              lat_in_win;
    logic              after_fetch;

    // Decode the accepted cycle and the window membership of the bus address.
    always_comb begin
        sampled  = stb && ack;
        in_win   = addr[ADDR_W-1:WIN_LOG2] == WIN_TAG;
        hit_vld  = sampled && fetch && in_win;
        miss_vld = sampled && fetch && !in_win;
        hit_idx  = addr[WIN_LOG2-1:0];
    end

    // Hold the last fetch and mark the accepted cycle that follows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr    <= '0;
            lat_opc     <= '0;
            lat_in_win  <= 1'b0;
            after_fetch <= 1'b0;
        end else if (sampled) begin
            after_fetch <= fetch;
            if (fetch) begin
                lat_addr   <= addr;
                lat_opc    <= rdata;
                lat_in_win <= in_win;
            end
        end
    end

    // Resolve a held branch into its bin on the following accepted cycle.
    always_comb begin
        br_vld = sampled && after_fetch && lat_in_win && is_cond_branch(lat_opc);
        br_bin = {lat_addr[WIN_LOG2-1:0], taken};
    end

    a_r6_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_vld, miss_vld}));
    a_r1_idle_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && ack) |-> !(hit_vld || miss_vld || br_vld));
    a_r10_branch_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ack && !fetch) |=> !br_vld);
endmodule

// File: rtl/cov_counter_bank.sv
// Bank of saturating counters with one increment port, one combinational read
// port and a clear of all entries. Clear beats increment in the same cycle.
module cov_counter_bank #(
    parameter int DEPTH = 512,
    parameter int CNT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     inc,
    input  logic [$clog2(DEPTH)-1:0] inc_idx,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [CNT_W-1:0]         rd_cnt
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [DEPTH];

    // Clear all entries or bump the addressed one, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
        end else if (inc && cnt_q[inc_idx] != CNT_MAX) begin
            cnt_q[inc_idx] <= cnt_q[inc_idx] + CNT_W'(1);
        end
    end

    // Combinational readback of one entry.
    assign rd_cnt = cnt_q[rd_idx];

    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rd_cnt == CNT_MAX) |=> (rd_cnt == CNT_MAX || !$stable(rd_idx)));
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && rd_idx == inc_idx && rd_cnt != CNT_MAX)
        |=> (rd_cnt == $past(rd_cnt) + CNT_W'(1) || !$stable(rd_idx)));
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> rd_cnt == '0);
endmodule

// File: rtl/rom_fetch_cov.sv
// ROM fetch and branch coverage counter. Counts fetches per ROM address,
// branch outcomes per {address, taken}, and fetches outside the window.
// Assumes the window is aligned to its own size.
module rom_fetch_cov #(
    parameter int ADDR_W   = 16,
    parameter int WIN_LOG2 = 9,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFE00,
    parameter int CNT_W    = 8,
    parameter int OUT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic              ack,
    input  logic              fetch,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        rdata,
    input  logic              taken,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_taken,
    output logic [CNT_W-1:0]  rd_fetch_cnt,
    output logic [CNT_W-1:0]  rd_branch_cnt,
    output logic [OUT_W-1:0]  outside_cnt
);
    localparam int WIN_DEPTH = 1 << WIN_LOG2;
    localparam int TAG_W     = ADDR_W - WIN_LOG2;
    localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];
    localparam logic [OUT_W-1:0] OUT_MAX = '1;

    logic                hit_vld, miss_vld, br_vld;
    logic [WIN_LOG2-1:0] hit_idx;
    logic [WIN_LOG2:0]   br_bin;
    logic [CNT_W-1:0]    fetch_raw, branch_raw;
    logic                rd_in_win;

    cov_fetch_capture #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)) u_cap (
        .clk(clk), .rst_n(rst_n), .stb(stb), .ack(ack), .fetch(fetch),
        .addr(addr), .rdata(rdata), .taken(taken),
        .hit_vld(hit_vld), .hit_idx(hit_idx), .miss_vld(miss_vld),
        .br_vld(br_vld), .br_bin(br_bin)
    );

    cov_counter_bank #(.DEPTH(WIN_DEPTH), .CNT_W(CNT_W)) u_fetch_bank (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(hit_vld), .inc_idx(hit_idx),
        .rd_idx(rd_addr[WIN_LOG2-1:0]), .rd_cnt(fetch_raw)
    );

    cov_counter_bank #(.DEPTH(2 * WIN_DEPTH), .CNT_W(CNT_W)) u_branch_bank (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(br_vld), .inc_idx(br_bin),
        .rd_idx({rd_addr[WIN_LOG2-1:0], rd_taken}), .rd_cnt(branch_raw)
    );

    // Count fetches that fall outside the window, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            outside_cnt <= '0;
        end else if (miss_vld && outside_cnt != OUT_MAX) begin
            outside_cnt <= outside_cnt + OUT_W'(1);
        end
    end

    // Return zero for readback addresses outside the window.
    always_comb begin
        rd_in_win     = rd_addr[ADDR_W-1:WIN_LOG2] == WIN_TAG;
        rd_fetch_cnt  = rd_in_win ? fetch_raw  : '0;
        rd_branch_cnt = rd_in_win ? branch_raw : '0;
    end

    a_r6_outside_step: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ack && fetch && addr[ADDR_W-1:WIN_LOG2] != WIN_TAG && !clr
         && outside_cnt != OUT_MAX) |=> outside_cnt == $past(outside_cnt) + OUT_W'(1));
    a_r6_outside_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(stb && ack && fetch)) |=> $stable(outside_cnt));
    a_r9_outside_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr[ADDR_W-1:WIN_LOG2] != WIN_TAG) |-> (rd_fetch_cnt == '0 && rd_branch_cnt == '0));
endmodule

// File: tb/sim_rom_fetch_cov.sv
module sim_rom_fetch_cov;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, clr = 1'b0, stb = 1'b0, ack = 1'b0, fetch = 1'b0, taken = 1'b0;
    logic [15:0] addr = '0, rd_addr = '0;
    logic [7:0]  rdata = '0;
    logic        rd_taken = 1'b0;
    logic [7:0]  rd_fetch_cnt, rd_branch_cnt;
    logic [15:0] outside_cnt;

    int compared = 0, mismatched = 0;
    bit done = 0;

    int ref_f [512];
    int ref_b [1024];
    int ref_out;
    logic [15:0] m_addr;
    logic [7:0]  m_opc;
    bit          m_after;

    always #5 clk = ~clk;

    rom_fetch_cov u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .stb(stb), .ack(ack), .fetch(fetch),
        .addr(addr), .rdata(rdata), .taken(taken), .rd_addr(rd_addr), .rd_taken(rd_taken),
        .rd_fetch_cnt(rd_fetch_cnt), .rd_branch_cnt(rd_branch_cnt), .outside_cnt(outside_cnt)
    );

    function automatic bit in_win(input logic [15:0] a);
        return a >= 16'hFE00;
    endfunction

    function automatic int sat(input int v, input int mx);
        return (v < mx) ? v + 1 : mx;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear_counts();
        for (int i = 0; i < 512; i++) ref_f[i] = 0;
        for (int i = 0; i < 1024; i++) ref_b[i] = 0;
        ref_out = 0;
    endtask

    // One clock: drive at negedge, update the reference at the posedge, then idle.
    task automatic cyc(input bit r, input bit c, input bit s, input bit a, input bit f,
                       input logic [15:0] ad, input logic [7:0] d, input bit t);
        @(negedge clk);
        rst_n = r; clr = c; stb = s; ack = a; fetch = f; addr = ad; rdata = d; taken = t;
        @(posedge clk);
        if (!r) begin
            model_clear_counts();
            m_addr = '0; m_opc = '0; m_after = 0;
        end else begin
            if (s && a) begin
                if (m_after && in_win(m_addr) && m_opc[4:0] == 5'h10)
                    ref_b[{m_addr[8:0], t}] = sat(ref_b[{m_addr[8:0], t}], 255);
                if (f) begin
                    if (in_win(ad)) ref_f[ad[8:0]] = sat(ref_f[ad[8:0]], 255);
                    else ref_out = sat(ref_out, 65535);
                    m_addr = ad; m_opc = d;
                end
                m_after = f;
            end
            if (c) model_clear_counts();
        end
        #1;
        rst_n = 1'b1; clr = 1'b0; stb = 1'b0; ack = 1'b0; fetch = 1'b0;
    endtask

    task automatic read_addr(input logic [15:0] a, input string req);
        int ef, e0, e1;
        ef = in_win(a) ? ref_f[a[8:0]] : 0;
        e0 = in_win(a) ? ref_b[{a[8:0], 1'b0}] : 0;
        e1 = in_win(a) ? ref_b[{a[8:0], 1'b1}] : 0;
        rd_addr = a; rd_taken = 1'b0; #1;
        chk(req, $sformatf("fetch cnt @%h", a), rd_fetch_cnt, ef);
        chk(req, $sformatf("fallthru bin @%h", a), rd_branch_cnt, e0);
        rd_taken = 1'b1; #1;
        chk(req, $sformatf("taken bin @%h", a), rd_branch_cnt, e1);
    endtask

    task automatic full_check(input string req);
        for (int i = 0; i < 512; i++) read_addr(16'hFE00 + 16'(i), req);
        read_addr(16'hFDFF, "R9"); read_addr(16'h0000, "R9"); read_addr(16'h7E00, "R9");
        chk(req, "outside count", outside_cnt, ref_out);
    endtask

    initial begin
        model_clear_counts();
        m_addr = '0; m_opc = '0; m_after = 0;
        void'($urandom(32'd2718));

        // R8: reset while the bus is busy counts nothing.
        cyc(0, 0, 1, 1, 1, 16'hFE10, 8'h00, 0);
        cyc(0, 0, 1, 1, 1, 16'h1234, 8'h00, 0);
        read_addr(16'hFE10, "R8");
        chk("R8", "outside count after reset", outside_cnt, 0);

        // R1: strobe without acknowledge, and acknowledge without strobe.
        cyc(1, 0, 1, 0, 1, 16'hFE20, 8'h10, 0);
        cyc(1, 0, 0, 1, 1, 16'hFE20, 8'h10, 1);
        cyc(1, 0, 1, 0, 0, 16'hFE20, 8'h00, 1);
        read_addr(16'hFE20, "R1");

        // R4/R10: branch at FE05, outcome delayed by unaccepted cycles.
        cyc(1, 0, 1, 1, 1, 16'hFE05, 8'hF0, 0);
        cyc(1, 0, 0, 0, 0, 16'h0000, 8'h00, 0);
        cyc(1, 0, 1, 0, 0, 16'h0000, 8'h00, 0);
        cyc(1, 0, 1, 1, 0, 16'hFE06, 8'h00, 1);
        read_addr(16'hFE05, "R10");
        chk("R4", "FE05 taken bin", ref_b[{9'h005, 1'b1}], 1);
        // R5: non-branch opcode followed by accepted cycle.
        cyc(1, 0, 1, 1, 1, 16'hFE07, 8'h11, 1);
        cyc(1, 0, 1, 1, 0, 16'h0000, 8'h00, 1);
        read_addr(16'hFE07, "R5");
        // R10: branch opcode fetched outside window, then fetch in window.
        cyc(1, 0, 1, 1, 1, 16'hFDFF, 8'h10, 0);
        cyc(1, 0, 1, 1, 1, 16'hFE00, 8'h00, 0);
        read_addr(16'hFE00, "R10");
        read_addr(16'hFDFF, "R9");
        chk("R6", "outside after FDFF fetch", outside_cnt, ref_out);

        // R7: clear in the same cycle as a window fetch.
        cyc(1, 1, 1, 1, 1, 16'hFE30, 8'h00, 0);
        read_addr(16'hFE30, "R7");
        read_addr(16'hFE05, "R7");
        chk("R7", "outside after clear", outside_cnt, 0);

        // R3: fetch saturation at FFFF and branch saturation at FE00.
        for (int i = 0; i < 300; i++) cyc(1, 0, 1, 1, 1, 16'hFFFF, 8'h00, 0);
        for (int i = 0; i < 300; i++) begin
            cyc(1, 0, 1, 1, 1, 16'hFE00, 8'h30, 1);
            cyc(1, 0, 1, 1, 0, 16'h0000, 8'h00, 1);
        end
        read_addr(16'hFFFF, "R3");
        read_addr(16'hFE00, "R3");
        chk("R3", "FFFF fetch saturated", ref_f[511], 255);

        // R2/R4/R5/R6: constrained random traffic.
        for (int i = 0; i < 4000; i++) begin
            bit s, a, f, t, c;
            logic [15:0] ad;
            logic [7:0] d;
            int sel;
            s = ($urandom % 8) != 0;
            a = ($urandom % 8) != 0;
            f = $urandom % 2;
            t = $urandom % 2;
            c = ($urandom % 1500) == 0;
            sel = $urandom % 10;
            if (sel < 6) ad = 16'hFE00 + 16'($urandom % 24);
            else if (sel < 8) ad = 16'hFFF0 + 16'($urandom % 16);
            else ad = 16'($urandom);
            d = ($urandom % 3 == 0) ? {3'($urandom), 5'h10} : 8'($urandom);
            cyc(1, c, s, a, f, ad, d, t);
        end
        full_check("R2");

        // R6: outside counter saturation.
        for (int i = 0; i < 65600; i++) cyc(1, 0, 1, 1, 1, 16'h0100, 8'h00, 0);
        chk("R6", "outside saturated", outside_cnt, 65535);
        chk("R6", "model outside saturated", ref_out, 65535);
        read_addr(16'hFE00, "R6");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule